// File: doc/BRIEF.md
# Shift-Select Constant Multiplier for Integer Transforms

This block forms the product of a signed sample and one integer transform coefficient with no general multiplier. Each coefficient magnitude is written as a sum of at most five power-of-two multiples of the sample. Five selector cells each pass either a left-shifted copy of the sample magnitude or zero. A carry-save reduction of fixed depth folds the five terms into a sum vector and a carry vector, and a single carry-propagate adder joins them. The sign is handled apart from the magnitude: the magnitude result is negated when the sample sign and the coefficient sign differ.

The coefficient comes from a 32-entry constant table picked by an index, or, in direct mode, from five shift codes given on a port. The inputs are registered, the product is registered one cycle later, and the output is a full-width two's-complement value. Because every coefficient passes through the same five cells and the same three adder levels, the delay does not change with the number of set bits in the coefficient.

Top module: `csa_const_mult`

## Requirements
- R1: While rst_ni is low, and after its release until valid inputs have passed through, product_o is zero.
- R2: Inputs present at a rising clock edge k give their product on product_o after edge k+1 (two-edge latency); a new input may be applied every cycle.
- R3: With dir_en_i low, product_o equals sample_i times M, or times -M when coef_neg_i is 1, where M is the table entry for coef_idx_i: index 0..31 maps to 0, 64, 83, 36, 89, 75, 50, 18, 90, 88, 85, 82, 78, 73, 67, 61, 54, 46, 38, 31, 22, 13, 4, 87, 80, 70, 57, 43, 25, 9, 1, 2.
- R4: Index 0 uses the zero select code in every cell and yields a product of 0 for any sample and either sign.
- R5: A table coefficient with a single set bit (1, 2, 4, 64) yields exactly the sample shifted by that power of two, with the remaining four cells contributing zero.
- R6: Coefficients that need all five terms (87, 61, 31) produce exact products.
- R7: The product is negative when exactly one of the sample sign bit and coef_neg_i is set, and non-negative otherwise.
- R8: The most negative sample (-32768) and the largest sample (32767) produce exact full-width results, with product_o sign-extended to its 26 bits.
- R9: With dir_en_i high, coef_idx_i is ignored and the magnitude is the sum over cells j=0..4 of the term coded by dir_sel_i[3j+2:3j]: code 0 gives zero, code c in 1..7 gives sample magnitude shifted left by c-1; the same shift may appear in several cells.
- R10: A zero sample gives a zero product for every coefficient and sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed input sample |
| coef_idx_i | input | 5 | Coefficient table index |
| coef_neg_i | input | 1 | Coefficient sign, 1 for negative |
| dir_en_i | input | 1 | Use dir_sel_i instead of the table |
| dir_sel_i | input | 15 | Five 3-bit shift codes, cell j in bits 3j+2:3j |
| product_o | output | 26 | Signed product, registered |

## Verification
The assertions check on every cycle that the carry-save sum and carry vectors add up to the plain sum of the five selected terms, that a nonzero product carries the sign expected from the sample sign and coefficient sign two cycles earlier, and that a zero sample or the zero index gives a zero product. Exact product values for each table entry, the two-cycle latency under back-to-back inputs, the full-range extremes and the direct shift-code mode, including repeated shifts and the ignored index, are shown only by the bench scenarios comparing against products computed from the coefficient list.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

  localparam int unsigned NCELL     = 5;
  localparam int unsigned MAX_SHIFT = 6;
  localparam int unsigned SEL_W     = $clog2(MAX_SHIFT + 2);
  localparam int unsigned NCOEF     = 32;
  localparam int unsigned IDX_W     = $clog2(NCOEF);

  typedef logic [NCELL-1:0][SEL_W-1:0] sel_vec_t;

  function automatic int unsigned coef_mag(input int unsigned idx);
    case (idx)
      0:  return 0;
      1:  return 64;
      2:  return 83;
      3:  return 36;
      4:  return 89;
      5:  return 75;
      6:  return 50;
      7:  return 18;
      8:  return 90;
      9:  return 88;
      10: return 85;
      11: return 82;
      12: return 78;
      13: return 73;
      14: return 67;
      15: return 61;
      16: return 54;
      17: return 46;
      18: return 38;
      19: return 31;
      20: return 22;
      21: return 13;
      22: return 4;
      23: return 87;
      24: return 80;
      25: return 70;
      26: return 57;
      27: return 43;
      28: return 25;
      29: return 9;
      30: return 1;
      default: return 2;
    endcase
  endfunction

  // set bits, highest first, one per cell; unused cells get code 0
  function automatic sel_vec_t decompose(input int unsigned mag);
    sel_vec_t s;
    int unsigned n;
    s = '0;
    n = 0;
    for (int b = MAX_SHIFT; b >= 0; b--) begin
      if (mag[b] && n < NCELL) begin
        s[n] = SEL_W'(b + 1);
        n++;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/coef_rom.sv
module coef_rom
  import csa_mult_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output sel_vec_t         sel_o
);

  sel_vec_t rom_w [NCOEF];

  for (genvar i = 0; i < NCOEF; i++) begin : g_ent
    assign rom_w[i] = decompose(coef_mag(i));
  end

  assign sel_o = rom_w[idx_i];

endmodule

// File: rtl/shift_cell.sv
module shift_cell
  import csa_mult_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned MW = 25
) (
  input  logic [DW-1:0]    mag_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [MW-1:0]    term_o
);

  always_comb begin
    term_o = '0;
    for (int k = 0; k <= MAX_SHIFT; k++) begin
      if (sel_i == SEL_W'(k + 1)) term_o = MW'(mag_i) << k;
    end
  end

endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned W = 25
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] maj_w;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign maj_w   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign carry_o = {maj_w[W-2:0], 1'b0};

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import csa_mult_pkg::*;
#(
  parameter int unsigned W = 25
) (
  input  logic [NCELL-1:0][W-1:0] term_i,
  output logic [W-1:0]            sum_o,
  output logic [W-1:0]            carry_o
);

  localparam int unsigned NLVL = NCELL - 2;

  logic [W-1:0] s_w [NLVL+1];
  logic [W-1:0] c_w [NLVL+1];

  assign s_w[0] = term_i[0];
  assign c_w[0] = term_i[1];

  // each level folds one further term into the running sum/carry pair
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    csa_row #(.W(W)) i_row (
      .a_i    (s_w[l]),
      .b_i    (c_w[l]),
      .c_i    (term_i[l+2]),
      .sum_o  (s_w[l+1]),
      .carry_o(c_w[l+1])
    );
  end

  assign sum_o   = s_w[NLVL];
  assign carry_o = c_w[NLVL];

endmodule

// File: rtl/csa_const_mult.sv
module csa_const_mult
  import csa_mult_pkg::*;
#(
  parameter  int unsigned DW = 16,
  localparam int unsigned MW = DW + MAX_SHIFT + 3,
  localparam int unsigned PW = MW + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [DW-1:0]          sample_i,
  input  logic [IDX_W-1:0]       coef_idx_i,
  input  logic                   coef_neg_i,
  input  logic                   dir_en_i,
  input  logic [NCELL*SEL_W-1:0] dir_sel_i,
  output logic [PW-1:0]          product_o
);

  logic [DW-1:0]           abs_w;
  sel_vec_t                tab_sel_w;
  sel_vec_t                sel_w;
  logic [DW-1:0]           mag_q;
  sel_vec_t                sel_q;
  logic                    neg_q;
  logic [NCELL-1:0][MW-1:0] term_w;
  logic [MW-1:0]           csa_sum_w;
  logic [MW-1:0]           csa_carry_w;
  logic [MW-1:0]           mag_sum_w;
  logic [PW-1:0]           pos_w;
  logic [PW-1:0]           res_w;

  // most negative sample maps to 2^(DW-1), still fits DW unsigned bits
  assign abs_w = sample_i[DW-1] ? (~sample_i + DW'(1)) : sample_i;

  coef_rom i_rom (
    .idx_i(coef_idx_i),
    .sel_o(tab_sel_w)
  );

  assign sel_w = dir_en_i ? sel_vec_t'(dir_sel_i) : tab_sel_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      sel_q <= '0;
      neg_q <= 1'b0;
    end else begin
      mag_q <= abs_w;
      sel_q <= sel_w;
      neg_q <= sample_i[DW-1] ^ coef_neg_i;
    end
  end

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    shift_cell #(.DW(DW), .MW(MW)) i_cell (
      .mag_i (mag_q),
      .sel_i (sel_q[g]),
      .term_o(term_w[g])
    );
  end

  csa_tree #(.W(MW)) i_tree (
    .term_i (term_w),
    .sum_o  (csa_sum_w),
    .carry_o(csa_carry_w)
  );

  assign mag_sum_w = csa_sum_w + csa_carry_w;
  assign pos_w     = {1'b0, mag_sum_w};
  assign res_w     = neg_q ? (~pos_w + PW'(1)) : pos_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) product_o <= '0;
    else         product_o <= res_w;
  end

endmodule

// File: rtl/csa_mult_chk.sv
module csa_mult_chk
  import csa_mult_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned MW = DW + MAX_SHIFT + 3,
  parameter int unsigned PW = MW + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [DW-1:0]           sample_i,
  input logic [IDX_W-1:0]        coef_idx_i,
  input logic                    coef_neg_i,
  input logic                    dir_en_i,
  input logic [PW-1:0]           product_o,
  input logic [NCELL-1:0][MW-1:0] term_i,
  input logic [MW-1:0]           sum_i,
  input logic [MW-1:0]           carry_i
);

  logic [MW-1:0] plain_sum_w;

  always_comb begin
    plain_sum_w = '0;
    for (int j = 0; j < NCELL; j++) plain_sum_w = plain_sum_w + term_i[j];
  end

  AST_TREE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_i + carry_i) == plain_sum_w); // R3

  AST_PRODUCT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (product_o != '0) |-> (product_o[PW-1] == ($past(sample_i[DW-1], 2) ^ $past(coef_neg_i, 2)))); // R7

  AST_ZERO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_i, 2) == '0) |-> (product_o == '0)); // R10

  AST_ZERO_COEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!dir_en_i && (coef_idx_i == '0), 2)) |-> (product_o == '0)); // R4

endmodule

bind csa_const_mult csa_mult_chk #(.DW(DW), .MW(MW), .PW(PW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sample_i  (sample_i),
  .coef_idx_i(coef_idx_i),
  .coef_neg_i(coef_neg_i),
  .dir_en_i  (dir_en_i),
  .product_o (product_o),
  .term_i    (term_w),
  .sum_i     (csa_sum_w),
  .carry_i   (csa_carry_w)
);

// File: tb/test_csa_const_mult.sv
`timescale 1ns/1ps
module test_csa_const_mult;

  localparam int DW = 16;
  localparam int PW = 26;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   sample_i = '0;
  logic [4:0]    coef_idx_i = '0;
  logic          coef_neg_i = 1'b0;
  logic          dir_en_i = 1'b0;
  logic [14:0]   dir_sel_i = '0;
  logic [PW-1:0] product_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  csa_const_mult i_csa_const_mult (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_i),
    .coef_idx_i(coef_idx_i),
    .coef_neg_i(coef_neg_i),
    .dir_en_i  (dir_en_i),
    .dir_sel_i (dir_sel_i),
    .product_o (product_o)
  );

  function automatic longint tb_coef(input int i);
    int t [32] = '{0, 64, 83, 36, 89, 75, 50, 18, 90, 88, 85, 82, 78, 73, 67, 61,
                   54, 46, 38, 31, 22, 13, 4, 87, 80, 70, 57, 43, 25, 9, 1, 2};
    return longint'(t[i]);
  endfunction

  function automatic longint dir_mag(input logic [14:0] codes);
    longint m = 0;
    for (int j = 0; j < 5; j++) begin
      int c = int'(codes[3*j +: 3]);
      if (c != 0) m += longint'(1) << (c - 1);
    end
    return m;
  endfunction

  function automatic longint expect_of(input logic [15:0] s, input longint mag, input logic neg);
    longint v = longint'($signed(s)) * mag;
    return neg ? -v : v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint prod_val();
    return longint'($signed(product_o));
  endfunction

  // drive at negedge, result visible after the second following posedge
  task automatic run_one(input logic [15:0] s, input logic [4:0] idx, input logic neg,
                         input logic den, input logic [14:0] dsel, input string req);
    longint exp;
    @(negedge clk_i);
    sample_i = s; coef_idx_i = idx; coef_neg_i = neg; dir_en_i = den; dir_sel_i = dsel;
    exp = den ? expect_of(s, dir_mag(dsel), neg) : expect_of(s, tb_coef(int'(idx)), neg);
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, prod_val(), exp);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 during reset", prod_val(), 0);
    sample_i = 16'd1234; coef_idx_i = 5'd8;
    @(negedge clk_i);
    check("R1 reset holds", prod_val(), 0);
    rst_ni = 1'b1;
    sample_i = '0; coef_idx_i = '0;
    @(negedge clk_i);
    check("R1 after release", prod_val(), 0);
  endtask

  task automatic t_table_sweep();
    for (int i = 0; i < 32; i++) begin
      for (int s = -24; s < 24; s += 3) begin
        run_one(16'(s), 5'(i), 1'b0, 1'b0, '0, "R3 sweep pos");
        run_one(16'(s), 5'(i), 1'b1, 1'b0, '0, "R3 sweep neg");
      end
    end
  endtask

  task automatic t_zero_index();
    run_one(16'sd32767, 5'd0, 1'b0, 1'b0, '0, "R4 zero idx");
    run_one(16'h8000, 5'd0, 1'b1, 1'b0, '0, "R4 zero idx neg");
    run_one(16'hFFFF, 5'd0, 1'b0, 1'b0, '0, "R4 zero idx -1");
  endtask

  task automatic t_single_bit();
    run_one(16'sd301, 5'd30, 1'b0, 1'b0, '0, "R5 coef 1");
    run_one(16'sd301, 5'd31, 1'b0, 1'b0, '0, "R5 coef 2");
    run_one(-16'sd777, 5'd22, 1'b0, 1'b0, '0, "R5 coef 4");
    run_one(16'sd511, 5'd1, 1'b1, 1'b0, '0, "R5 coef 64");
  endtask

  task automatic t_five_terms();
    run_one(16'sd1000, 5'd23, 1'b0, 1'b0, '0, "R6 coef 87");
    run_one(-16'sd1999, 5'd15, 1'b0, 1'b0, '0, "R6 coef 61");
    run_one(16'sd4321, 5'd19, 1'b1, 1'b0, '0, "R6 coef 31");
  endtask

  task automatic t_sign();
    run_one(16'sd5, 5'd8, 1'b0, 1'b0, '0, "R7 pos*pos");
    run_one(16'sd5, 5'd8, 1'b1, 1'b0, '0, "R7 pos*neg");
    run_one(-16'sd5, 5'd8, 1'b0, 1'b0, '0, "R7 neg*pos");
    run_one(-16'sd5, 5'd8, 1'b1, 1'b0, '0, "R7 neg*neg");
    check("R7 neg*neg sign", longint'(product_o[PW-1]), 0);
  endtask

  task automatic t_extremes();
    run_one(16'h8000, 5'd8, 1'b0, 1'b0, '0, "R8 min*90");
    run_one(16'h8000, 5'd8, 1'b1, 1'b0, '0, "R8 min*-90");
    run_one(16'h7FFF, 5'd4, 1'b1, 1'b0, '0, "R8 max*-89");
    check("R8 sign ext", longint'(product_o[PW-1:PW-4]), 15);
    run_one(16'h8000, 5'd23, 1'b0, 1'b0, '0, "R8 min*87");
  endtask

  task automatic t_direct();
    run_one(16'sd100, 5'd8, 1'b0, 1'b1, {3'd7, 3'd7, 3'd7, 3'd7, 3'd7}, "R9 five x64");
    run_one(16'h8000, 5'd8, 1'b1, 1'b1, {3'd7, 3'd7, 3'd7, 3'd7, 3'd7}, "R9 min five x64");
    run_one(16'sd77, 5'd8, 1'b0, 1'b1, {3'd4, 3'd0, 3'd2, 3'd5, 3'd3}, "R9 mixed codes");
    run_one(16'sd77, 5'd23, 1'b0, 1'b1, '0, "R9 all zero codes idx ignored");
    run_one(-16'sd9, 5'd1, 1'b1, 1'b1, {3'd0, 3'd0, 3'd0, 3'd0, 3'd1}, "R9 unit code");
  endtask

  task automatic t_zero_sample();
    for (int i = 1; i < 32; i += 5) begin
      run_one('0, 5'(i), 1'b1, 1'b0, '0, "R10 zero sample");
    end
  endtask

  task automatic t_stream();
    longint exp_q [24];
    for (int i = 0; i < 26; i++) begin
      @(negedge clk_i);
      if (i >= 2) check("R2 back-to-back", prod_val(), exp_q[i-2]);
      if (i < 24) begin
        logic [15:0] s = 16'($urandom);
        logic [4:0]  k = 5'($urandom);
        logic        n = 1'($urandom);
        sample_i = s; coef_idx_i = k; coef_neg_i = n; dir_en_i = 1'b0;
        exp_q[i] = expect_of(s, tb_coef(int'(k)), n);
      end
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 32; i++) begin
      for (int r = 0; r < 6; r++) begin
        run_one(16'($urandom), 5'(i), 1'($urandom), 1'b0, '0, "R3 random full range");
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_table_sweep();
    t_zero_index();
    t_single_bit();
    t_five_terms();
    t_sign();
    t_extremes();
    t_direct();
    t_zero_sample();
    t_stream();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule